// File: doc/BRIEF.md
# Reply Pulse Detector and Code Assembler

This block takes a stream of envelope amplitude samples, one per clock at an 80 MSPS sample rate, and finds transponder reply pulses in it. A run of samples above a programmable threshold is one pulse candidate. The block measures how many samples the run lasts and the largest sample it contains. It reports every run, and it accepts a run only if its width lies in the allowed window.

Accepted pulses then drive a small framing engine. The first accepted pulse opens a frame, and its leading-edge sample is time zero. Any later accepted pulse whose leading edge falls near one of the fixed slot centres marks that slot present. A closing pulse near the far end of the frame completes the reply. The block then issues a 12-bit identity code or, in short mode, a 4-bit military code, together with a one-cycle strobe. A frame that never closes is dropped after a timeout.

Top module: `reply_decoder`

## Requirements
- R1: A pulse candidate starts only on a sample strictly greater than `thr`. A run whose samples equal `thr` produces no pulse report.
- R2: After the first sample at or below `thr` that ends a run, `pulse_done` is high for exactly one cycle. In that cycle `pulse_width` is the number of samples that were above `thr` and `pulse_peak` is the largest of those samples.
- R3: `pulse_ok` is 1 exactly when the width is between 24 and 48 samples, inclusive. This corresponds to 0.3 to 0.6 µs.
- R4: The first accepted pulse opens a frame, with its leading-edge sample as time 0. An accepted pulse whose leading edge lies within 1616..1632 samples (1624 ±8) closes the frame. `code_valid` is then high for one cycle, in the same cycle as that pulse's `pulse_done`.
- R5: Slot k, for k = 1..13, is centred at k×116 samples. A slot is present only if an accepted pulse's leading edge lies within ±8 samples of that centre. Pulses with a rejected width, or with a leading edge outside every window, leave the code unchanged.
- R6: In identity mode (`short_mode`=0), code bits 11 down to 6 are slots 1 to 6 and bits 5 down to 0 are slots 8 to 13. Slot 7 is ignored.
- R7: In short mode (`short_mode`=1), code bits 3 down to 0 are slots 1 to 4, and bits 11 to 4 are zero. Slots 5 to 13 are ignored.
- R8: If no closing pulse is accepted, no `code_valid` is issued. Once time passes 1632 with no pulse in progress, the block returns to idle, and the next pulse opens a new frame.
- R9: A first pulse with a rejected width opens no frame. A valid reply that starts after it decodes normally.
- R10: After reset, `code_valid`, `pulse_done` and `code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one envelope sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| env | input | 12 | Envelope amplitude sample |
| thr | input | 12 | Detection threshold |
| short_mode | input | 1 | 1 selects the 4-bit short military code |
| pulse_done | output | 1 | One-cycle strobe at the end of each above-threshold run |
| pulse_ok | output | 1 | The reported run has an accepted width |
| pulse_width | output | 8 | Width of the reported run, in samples (saturating) |
| pulse_peak | output | 12 | Peak amplitude of the reported run |
| code_valid | output | 1 | One-cycle strobe when a framed reply completes |
| code | output | 12 | Assembled reply code |

## Verification
Identity replies are swept over all-zero, all-one, alternating patterns and every single-bit code, so the bench can tell a misplaced slot-to-bit mapping from a dropped slot. All 16 short codes are sent with slots 5 to 13 also filled, which exposes any leakage of upper slots. Pulse widths of 23, 24, 48 and 49 samples, leading-edge offsets of ±8 and ±9 samples, and closing pulses just inside and just outside their window each bracket one boundary. Replies with a missing or misplaced closing pulse, and ones preceded by a rejected first pulse, separate correct timeout and restart from a stuck frame.

// File: rtl/reply_decoder.sv
module reply_decoder #(
  parameter int AMP_W     = 12,
  parameter int CNT_W     = 8,
  parameter int MIN_W     = 24,
  parameter int MAX_W     = 48,
  parameter int SLOT_STEP = 116,
  parameter int SLOT_TOL  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AMP_W-1:0] env,
  input  logic [AMP_W-1:0] thr,
  input  logic             short_mode,
  output logic             pulse_done,
  output logic             pulse_ok,
  output logic [CNT_W-1:0] pulse_width,
  output logic [AMP_W-1:0] pulse_peak,
  output logic             code_valid,
  output logic [11:0]      code
);
  localparam int PH_W = $clog2(SLOT_STEP);
  localparam int NSLOT = 14;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_STEP - 1);
  localparam logic [PH_W-1:0] TOL_LO  = PH_W'(SLOT_TOL);
  localparam logic [PH_W-1:0] TOL_HI  = PH_W'(SLOT_STEP - SLOT_TOL);
  localparam logic [3:0] F2_SLOT = 4'(NSLOT);
  localparam logic [CNT_W-1:0] W_MIN = CNT_W'(MIN_W);
  localparam logic [CNT_W-1:0] W_MAX = CNT_W'(MAX_W);
  localparam logic [CNT_W-1:0] W_SAT = '1;

  typedef enum logic [1:0] {IDLE, CAND, FRAME} st_t;
  st_t st;

  logic             in_pulse;
  logic [CNT_W-1:0] wcnt;
  logic [AMP_W-1:0] peak;
  logic [PH_W-1:0]  ph;
  logic [3:0]       sidx;
  logic             hit_q;
  logic [3:0]       slot_q;
  logic [13:0]      slots;

  wire above    = env > thr;
  wire lead     = above & ~in_pulse;
  wire trail    = ~above & in_pulse;
  wire width_ok = (wcnt >= W_MIN) && (wcnt <= W_MAX);
  wire near_lo  = ph <= TOL_LO;
  wire near_hi  = ph >= TOL_HI;
  wire frozen   = (sidx == F2_SLOT) && (ph > TOL_LO);
  wire good_end = trail && width_ok && hit_q;
  wire f2_hit   = good_end && (slot_q == F2_SLOT);

  wire [11:0] ident_code = {slots[1], slots[2], slots[3], slots[4], slots[5], slots[6],
                            slots[8], slots[9], slots[10], slots[11], slots[12], slots[13]};
  wire [11:0] short_code = {8'b0, slots[1], slots[2], slots[3], slots[4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pulse    <= 1'b0;
      wcnt        <= '0;
      peak        <= '0;
      pulse_done  <= 1'b0;
      pulse_ok    <= 1'b0;
      pulse_width <= '0;
      pulse_peak  <= '0;
    end else begin
      pulse_done <= trail;
      if (lead) begin
        in_pulse <= 1'b1;
        wcnt     <= CNT_W'(1);
        peak     <= env;
      end else if (above) begin
        wcnt <= (wcnt == W_SAT) ? wcnt : wcnt + 1'b1;
        peak <= (env > peak) ? env : peak;
      end
      if (trail) begin
        in_pulse    <= 1'b0;
        pulse_ok    <= width_ok;
        pulse_width <= wcnt;
        pulse_peak  <= peak;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      ph         <= '0;
      sidx       <= '0;
      hit_q      <= 1'b0;
      slot_q     <= '0;
      slots      <= '0;
      code_valid <= 1'b0;
      code       <= '0;
    end else begin
      code_valid <= 1'b0;
      if (st != IDLE && !frozen) begin
        if (ph == PH_LAST) begin
          ph   <= '0;
          sidx <= sidx + 1'b1;
        end else begin
          ph <= ph + 1'b1;
        end
      end
      case (st)
        IDLE: if (lead) begin
          st    <= CAND;
          ph    <= PH_W'(1);
          sidx  <= '0;
          slots <= '0;
          hit_q <= 1'b0;
        end
        CAND: if (trail) st <= width_ok ? FRAME : IDLE;
        default: begin
          if (lead) begin
            hit_q  <= near_lo | near_hi;
            slot_q <= near_lo ? sidx : sidx + 1'b1;
          end
          if (good_end && slot_q != 4'd0 && slot_q < F2_SLOT) slots[slot_q] <= 1'b1;
          if (f2_hit) begin
            st         <= IDLE;
            code_valid <= 1'b1;
            code       <= short_mode ? short_code : ident_code;
          end else if (frozen && !in_pulse) begin
            st <= IDLE;
          end
        end
      endcase
    end
  end

  // R2
  pulse_done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_done |=> !pulse_done);
  // R3
  ok_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_done && pulse_ok) |-> (pulse_width >= W_MIN && pulse_width <= W_MAX));
  // R4
  code_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |-> (pulse_done && pulse_ok));
  // R4
  code_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid |=> !code_valid);
  // R7
  short_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && $past(short_mode)) |-> (code[11:4] == 8'd0));
endmodule

// File: tb/reply_decoder_tb.sv
`timescale 1ns/1ps
module reply_decoder_tb;
  localparam int STEP = 116;
  localparam int F2T  = 1624;
  localparam int LONG = 1700;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] env = '0;
  logic [11:0] thr = 12'd100;
  logic        short_mode = 1'b0;
  logic        pulse_done, pulse_ok, code_valid;
  logic [7:0]  pulse_width;
  logic [11:0] pulse_peak, code;

  reply_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .env(env), .thr(thr), .short_mode(short_mode),
    .pulse_done(pulse_done), .pulse_ok(pulse_ok), .pulse_width(pulse_width),
    .pulse_peak(pulse_peak), .code_valid(code_valid), .code(code));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int nvalid = 0, npulse = 0;
  int last_code = 0, last_w = 0, last_p = 0, last_ok = 0;

  always @(negedge clk) begin
    if (code_valid) begin nvalid++; last_code = int'(code); end
    if (pulse_done) begin
      npulse++; last_w = int'(pulse_width); last_p = int'(pulse_peak); last_ok = int'(pulse_ok);
    end
  end

  int ps[32], pw[32], pa[32];
  int np = 0;

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add(input int s, input int w, input int a);
    ps[np] = s; pw[np] = w; pa[np] = a; np++;
  endtask

  function automatic int level(input int t);
    int lv = 0;
    for (int k = 0; k < np; k++)
      if (t >= ps[k] && t < ps[k] + pw[k] && pa[k] > lv) lv = pa[k];
    return lv;
  endfunction

  task automatic run(input int tail);
    int last = 0;
    for (int k = 0; k < np; k++) if (ps[k] + pw[k] > last) last = ps[k] + pw[k];
    for (int t = 0; t < last + tail; t++) begin
      @(negedge clk);
      env = 12'(level(t));
    end
    @(negedge clk); env = '0;
    @(negedge clk);
    np = 0;
  endtask

  task automatic frame(input logic [13:1] sl, input bit with_f2, input int f2off, input int tail);
    np = 0;
    add(0, 30, 500);
    for (int k = 1; k <= 13; k++) if (sl[k]) add(k * STEP, 30, 500);
    if (with_f2) add(F2T + f2off, 30, 500);
    run(tail);
  endtask

  function automatic logic [13:1] ident_slots(input logic [11:0] c);
    logic [13:1] s = '0;
    for (int j = 0; j < 6; j++) s[j + 1] = c[11 - j];
    for (int j = 6; j < 12; j++) s[j + 2] = c[11 - j];
    return s;
  endfunction

  task automatic expect_reply(input string req, input int v0, input int expv, input int expc);
    check_eq(req, "valid count", nvalid - v0, expv);
    if (expv == 1) check_eq(req, "code", last_code, expc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int v0, p0;
    logic [13:1] s;
    repeat (4) @(negedge clk);
    // R10 reset state
    check_eq("R10", "code_valid", int'(code_valid), 0);
    check_eq("R10", "pulse_done", int'(pulse_done), 0);
    check_eq("R10", "code", int'(code), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 identity patterns
    begin
      int pats[4] = '{0, 12'hFFF, 12'hA5A, 12'h5A5};
      foreach (pats[i]) begin
        v0 = nvalid;
        frame(ident_slots(12'(pats[i])), 1'b1, 0, 20);
        expect_reply("R6", v0, 1, pats[i]);
      end
    end
    for (int b = 0; b < 12; b++) begin
      v0 = nvalid;
      frame(ident_slots(12'(1 << b)), 1'b1, 0, 20);
      expect_reply("R6", v0, 1, 1 << b);
    end
    // R6 slot 7 ignored
    s = '0; s[7] = 1'b1;
    v0 = nvalid; frame(s, 1'b1, 0, 20);
    expect_reply("R6", v0, 1, 0);

    // R7 short codes, slots 5..13 filled and ignored
    short_mode = 1'b1;
    for (int c = 0; c < 16; c++) begin
      s = '0; s[13:5] = '1;
      s[1] = c[3]; s[2] = c[2]; s[3] = c[1]; s[4] = c[0];
      v0 = nvalid; frame(s, 1'b1, 0, 20);
      expect_reply("R7", v0, 1, c);
    end
    short_mode = 1'b0;

    // R5 leading-edge tolerance around slot 1
    begin
      int offs[4] = '{8, -8, 9, -9};
      int exps[4] = '{12'h800, 12'h800, 0, 0};
      foreach (offs[i]) begin
        np = 0; add(0, 30, 500); add(STEP + offs[i], 30, 500); add(F2T, 30, 500);
        v0 = nvalid; run(20);
        expect_reply("R5", v0, 1, exps[i]);
      end
    end
    // R5 width-rejected information pulse does not set a slot (R3 boundaries)
    begin
      int ws[4] = '{23, 24, 48, 49};
      int exps[4] = '{0, 12'h800, 12'h800, 0};
      foreach (ws[i]) begin
        np = 0; add(0, 30, 500); add(STEP, ws[i], 500); add(F2T, 30, 500);
        v0 = nvalid; run(20);
        expect_reply("R5", v0, 1, exps[i]);
      end
    end

    // R4 closing pulse window
    v0 = nvalid; frame('0, 1'b1, 8, 20);   expect_reply("R4", v0, 1, 0);
    v0 = nvalid; frame('0, 1'b1, -8, 20);  expect_reply("R4", v0, 1, 0);
    v0 = nvalid; frame('0, 1'b1, 9, LONG); expect_reply("R4", v0, 0, 0);
    v0 = nvalid; frame('0, 1'b1, -9, LONG); expect_reply("R4", v0, 0, 0);

    // R8 missing closing pulse, then a fresh reply decodes
    v0 = nvalid; frame(ident_slots(12'h123), 1'b0, 0, LONG);
    expect_reply("R8", v0, 0, 0);
    v0 = nvalid; frame(ident_slots(12'h456), 1'b1, 0, 20);
    expect_reply("R8", v0, 1, 12'h456);

    // R9 rejected first pulse then a valid reply
    np = 0; add(0, 20, 500);
    add(200, 30, 500); add(200 + STEP * 2, 30, 500); add(200 + F2T, 30, 500);
    v0 = nvalid; run(20);
    expect_reply("R9", v0, 1, 12'h400);

    // R1 threshold strictness
    np = 0; add(0, 30, 100); p0 = npulse; run(LONG);
    check_eq("R1", "pulses at thr", npulse - p0, 0);
    np = 0; add(0, 30, 101); p0 = npulse; run(LONG);
    check_eq("R1", "pulses above thr", npulse - p0, 1);
    check_eq("R1", "width", last_w, 30);

    // R3 lone pulse width limits
    begin
      int ws[4] = '{23, 24, 48, 49};
      int oks[4] = '{0, 1, 1, 0};
      foreach (ws[i]) begin
        np = 0; add(0, ws[i], 700); p0 = npulse; run(LONG);
        check_eq("R3", "report count", npulse - p0, 1);
        check_eq("R3", "width", last_w, ws[i]);
        check_eq("R3", "ok", last_ok, oks[i]);
      end
    end

    // R2 peak and width over a shaped pulse
    np = 0; add(0, 30, 300); add(10, 5, 900); add(20, 3, 600);
    p0 = npulse; run(LONG);
    check_eq("R2", "report count", npulse - p0, 1);
    check_eq("R2", "width", last_w, 30);
    check_eq("R2", "peak", last_p, 900);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule